// File: doc/BRIEF.md
# Iterative 64-bit Feistel Block Cipher Engine

This block encrypts or decrypts one 64-bit block at a time under a 256-bit key. It has a single round unit and reuses it on every clock, so a block takes 32 round cycles. The caller presents a key, a data block and a direction bit, and pulses `start_i`. The engine captures all three on that edge and runs the 32 rounds. It then places the result on `block_o` and raises `done_o` for one cycle.

Each block is processed on its own, in electronic-codebook fashion. No state carries over from one block to the next apart from the held output. The substitution table set is fixed when the block is built, by the `SBOX_SET` parameter. Two sets are built in: the parameter-Z set and the hash test-parameter set.

Top module: `feistel64_core`

## Requirements
- R1: The key is read as eight 32-bit subkeys, with K0 = key_i[255:224] down to K7 = key_i[31:0]. block_i[63:32] is the left half and block_i[31:0] is the right half. With SBOX_SET=0, key ffeeddccbbaa99887766554433221100f0f1f2f3f4f5f6f7f8f9fafbfcfdfeff encrypts fedcba9876543210 to 4ee901e5c2d8ca3d.
- R2: Each round computes (right + subkey) mod 2^32. Nibble n of that sum, counted from bit 0 upward, goes through substitution box n. The result is rotated left by 11 bits and XORed into the left half, and then the two halves swap.
- R3: With decrypt_i=0 the subkeys are used in the order K0..K7 three times, followed by K7..K0 once.
- R4: With decrypt_i=1 the subkeys are used in the order K0..K7 once, followed by K7..K0 three times. Decrypting a ciphertext under the same key returns the original plaintext.
- R5: No half swap follows round 32. block_o[63:32] holds the left half after the last XOR, and block_o[31:0] holds the right half that fed that round.
- R6: done_o is high for exactly one cycle. It rises on the 32nd rising edge after the edge that accepts start_i.
- R7: While a block is in progress, start_i is ignored, and so are changes to key_i, block_i and decrypt_i. The block in progress finishes with the result of the values captured when it was accepted.
- R8: After reset, block_o is 0 and done_o is 0. block_o changes only on the cycle that done_o rises, and otherwise holds its value.
- R9: SBOX_SET selects the substitution tables: 0 selects the parameter-Z set and 1 selects the hash test-parameter set.
- R10: The output depends only on the block's own inputs. Running the same key, data and direction twice gives the same result, whatever ran in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Starts a block when the engine is idle |
| decrypt_i | input | 1 | 0 = encrypt, 1 = decrypt, captured with start |
| key_i | input | 256 | Cipher key, captured with start |
| block_i | input | 64 | Input block, captured with start |
| block_o | output | 64 | Result block, held until the next completion |
| done_o | output | 1 | One-cycle pulse when block_o is updated |

## Verification
The bench builds two copies of the engine side by side. One has SBOX_SET=0, so the published parameter-Z known-answer vector can check the whole datapath end to end. The other has SBOX_SET=1, which checks that the parameter really switches to the other table set; both copies are compared against a behavioural model. With both copies running on the same stimulus, the bench covers encrypt/decrypt round trips on random data, a restart attempt and input changes in the middle of a block, and repeated identical blocks.

// File: rtl/feistel64_pkg.sv
package feistel64_pkg;

  localparam int unsigned SBOX_SETS = 2;

  // Each entry packs one 4-bit box: output for input x sits at bits [4x+3:4x].
  localparam logic [63:0] TAB_Z [8] = '{
    64'h1F307D8E9B5A264C, 64'hF0DB74E1C5A93286,
    64'h069C471EDAF2853B, 64'hB9E35A076F4D128C,
    64'hC24BE390D618A5F7, 64'h0E34187BAC296FD5,
    64'h73AD0B4FC19652E8, 64'h2BC96AF43850DE71
  };

  localparam logic [63:0] TAB_T [8] = '{
    64'h35F7C1B6E08D29A4, 64'h95701832AFD6C4BE,
    64'hB9067CFE243AD185, 64'h352BC64EF9801AD7,
    64'h2B30E9A48DF517C6, 64'hEFC95863D1270AB4,
    64'hC2867EA095F314BD, 64'hC8B6E3294A750DF1
  };

  function automatic logic [3:0] sbox_nib(input int unsigned set,
                                          input logic [2:0] box,
                                          input logic [3:0] x);
    logic [63:0] row;
    row = (set == 1) ? TAB_T[box] : TAB_Z[box];
    return row[{x, 2'b00} +: 4];
  endfunction

endpackage

// File: rtl/feistel64_round.sv
module feistel64_round #(
  parameter int unsigned HALF_W   = 32,
  parameter int unsigned ROT      = 11,
  parameter int unsigned SBOX_SET = 0
) (
  input  logic [HALF_W-1:0] right_i,
  input  logic [HALF_W-1:0] subkey_i,
  output logic [HALF_W-1:0] mix_o
);
  localparam int unsigned NIBS = HALF_W / 4;

  logic [HALF_W-1:0] sum;
  logic [HALF_W-1:0] subst;

  assign sum = right_i + subkey_i;

  for (genvar g = 0; g < NIBS; g++) begin : g_box
    assign subst[4*g +: 4] = feistel64_pkg::sbox_nib(SBOX_SET, 3'(g), sum[4*g +: 4]);
  end

  assign mix_o = {subst[HALF_W-1-ROT:0], subst[HALF_W-1:HALF_W-ROT]};
endmodule

// File: rtl/feistel64_keysel.sv
module feistel64_keysel #(
  parameter int unsigned KEY_W  = 256,
  parameter int unsigned HALF_W = 32,
  parameter int unsigned ROUNDS = 32,
  parameter int unsigned CNT_W  = 5
) (
  input  logic [KEY_W-1:0]  key_i,
  input  logic [CNT_W-1:0]  round_i,
  input  logic              decrypt_i,
  output logic [HALF_W-1:0] subkey_o
);
  localparam int unsigned NWORDS = KEY_W / HALF_W;
  localparam int unsigned IDX_W  = $clog2(NWORDS);
  localparam int unsigned PASSES = ROUNDS / NWORDS;
  localparam logic [CNT_W-1:0] ENC_TURN = CNT_W'((PASSES - 1) * NWORDS);
  localparam logic [CNT_W-1:0] DEC_TURN = CNT_W'(NWORDS);

  logic [HALF_W-1:0] words [NWORDS];
  logic [IDX_W-1:0]  pos;
  logic [IDX_W-1:0]  idx;
  logic              reverse;

  for (genvar j = 0; j < NWORDS; j++) begin : g_word
    assign words[j] = key_i[KEY_W-1-HALF_W*j -: HALF_W];
  end

  assign pos      = round_i[IDX_W-1:0];
  assign reverse  = decrypt_i ? (round_i >= DEC_TURN) : (round_i >= ENC_TURN);
  assign idx      = reverse ? ~pos : pos;
  assign subkey_o = words[idx];
endmodule

// File: rtl/feistel64_ctrl.sv
module feistel64_ctrl #(
  parameter int unsigned ROUNDS = 32,
  parameter int unsigned CNT_W  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  output logic             accept_o,
  output logic             busy_o,
  output logic             last_o,
  output logic [CNT_W-1:0] round_o
);
  localparam logic [CNT_W-1:0] LAST_RND = CNT_W'(ROUNDS - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  assign accept_o = start_i && !busy_q;
  assign last_o   = busy_q && (cnt_q == LAST_RND);
  assign busy_o   = busy_q;
  assign round_o  = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (accept_o) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (last_o) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/feistel64_core.sv
module feistel64_core #(
  parameter int unsigned BLOCK_W  = 64,
  parameter int unsigned KEY_W    = 256,
  parameter int unsigned ROUNDS   = 32,
  parameter int unsigned SBOX_SET = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic               decrypt_i,
  input  logic [KEY_W-1:0]   key_i,
  input  logic [BLOCK_W-1:0] block_i,
  output logic [BLOCK_W-1:0] block_o,
  output logic               done_o
);
  localparam int unsigned HALF_W = BLOCK_W / 2;
  localparam int unsigned CNT_W  = $clog2(ROUNDS);

  logic [HALF_W-1:0]  left_q, right_q;
  logic [KEY_W-1:0]   key_q;
  logic               dec_q;
  logic [BLOCK_W-1:0] out_q;
  logic               done_q;

  logic               accept, busy, last;
  logic [CNT_W-1:0]   round_idx;
  logic [HALF_W-1:0]  subkey, mix, new_left;

  feistel64_ctrl #(.ROUNDS(ROUNDS), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rst(rst), .start_i(start_i),
    .accept_o(accept), .busy_o(busy), .last_o(last), .round_o(round_idx)
  );

  feistel64_keysel #(.KEY_W(KEY_W), .HALF_W(HALF_W), .ROUNDS(ROUNDS), .CNT_W(CNT_W)) keysel_i (
    .key_i(key_q), .round_i(round_idx), .decrypt_i(dec_q), .subkey_o(subkey)
  );

  feistel64_round #(.HALF_W(HALF_W), .ROT(11), .SBOX_SET(SBOX_SET)) round_i (
    .right_i(right_q), .subkey_i(subkey), .mix_o(mix)
  );

  assign new_left = left_q ^ mix;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q  <= '0;
      right_q <= '0;
      key_q   <= '0;
      dec_q   <= 1'b0;
      out_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        left_q  <= block_i[BLOCK_W-1:HALF_W];
        right_q <= block_i[HALF_W-1:0];
        key_q   <= key_i;
        dec_q   <= decrypt_i;
      end else if (busy) begin
        if (last) begin
          out_q  <= {new_left, right_q};
          done_q <= 1'b1;
        end else begin
          left_q  <= right_q;
          right_q <= new_left;
        end
      end
    end
  end

  assign block_o = out_q;
  assign done_o  = done_q;
endmodule

// File: rtl/feistel64_checker.sv
module feistel64_checker #(
  parameter int unsigned BLOCK_W = 64,
  parameter int unsigned KEY_W   = 256,
  parameter int unsigned ROUNDS  = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               start_i,
  input logic               done_o,
  input logic [BLOCK_W-1:0] block_o,
  input logic               busy,
  input logic [KEY_W-1:0]   key_q
);
  localparam int unsigned CW = $clog2(ROUNDS + 3) + 1;
  localparam logic [CW-1:0] DONE_AT = CW'(ROUNDS + 1);
  localparam logic [CW-1:0] SAT     = {CW{1'b1}};

  logic [CW-1:0] since_q;

  always_ff @(posedge clk) begin
    if (rst)                          since_q <= '0;
    else if (start_i && !busy)        since_q <= CW'(1);
    else if (since_q != '0 && since_q != SAT) since_q <= since_q + 1'b1;
  end

  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r6_done_latency: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (since_q == DONE_AT));

  a_r6_done_not_missed: assert property (@(posedge clk) disable iff (rst)
    (since_q == DONE_AT) |-> done_o);

  a_r8_output_held: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(block_o));

  a_r7_key_kept: assert property (@(posedge clk) disable iff (rst)
    (busy && start_i) |=> $stable(key_q));
endmodule

bind feistel64_core feistel64_checker #(
  .BLOCK_W(BLOCK_W), .KEY_W(KEY_W), .ROUNDS(ROUNDS)
) chk_i (
  .clk(clk), .rst(rst), .start_i(start_i), .done_o(done_o),
  .block_o(block_o), .busy(busy), .key_q(key_q)
);

// File: tb/feistel64_core_tb_top.sv
module feistel64_core_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0;
  logic         decrypt_i = 1'b0;
  logic [255:0] key_i = '0;
  logic [63:0]  block_i = '0;
  logic [63:0]  out_z, out_t;
  logic         done_z, done_t;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  feistel64_core #(.SBOX_SET(0)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .decrypt_i(decrypt_i),
    .key_i(key_i), .block_i(block_i), .block_o(out_z), .done_o(done_z));

  feistel64_core #(.SBOX_SET(1)) dut_alt_i (
    .clk(clk), .rst(rst), .start_i(start_i), .decrypt_i(decrypt_i),
    .key_i(key_i), .block_i(block_i), .block_o(out_t), .done_o(done_t));

  localparam logic [63:0] MZ [8] = '{
    64'h1F307D8E9B5A264C, 64'hF0DB74E1C5A93286, 64'h069C471EDAF2853B, 64'hB9E35A076F4D128C,
    64'hC24BE390D618A5F7, 64'h0E34187BAC296FD5, 64'h73AD0B4FC19652E8, 64'h2BC96AF43850DE71};
  localparam logic [63:0] MT [8] = '{
    64'h35F7C1B6E08D29A4, 64'h95701832AFD6C4BE, 64'hB9067CFE243AD185, 64'h352BC64EF9801AD7,
    64'h2B30E9A48DF517C6, 64'hEFC95863D1270AB4, 64'hC2867EA095F314BD, 64'hC8B6E3294A750DF1};

  function automatic logic [63:0] model(input int set, input logic [255:0] k,
                                        input logic [63:0] blk, input bit dec);
    logic [31:0] a, b, s, t, nb;
    logic [63:0] row;
    int w;
    a = blk[63:32];
    b = blk[31:0];
    for (int i = 0; i < 32; i++) begin
      if (!dec) w = (i < 24) ? (i % 8) : (7 - i % 8);
      else      w = (i < 8)  ? (i % 8) : (7 - i % 8);
      s = b + k[255 - 32*w -: 32];
      for (int n = 0; n < 8; n++) begin
        row = (set == 1) ? MT[n] : MZ[n];
        t[4*n +: 4] = row[4*s[4*n +: 4] +: 4];
      end
      t = {t[20:0], t[31:21]};
      if (i == 31) return {a ^ t, b};
      nb = a ^ t;
      a = b;
      b = nb;
    end
    return '0;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Cycle-by-cycle behavioural model of both engines
  int          m_cnt = 0;
  bit          m_busy = 0, m_done = 0;
  logic [63:0] m_res_z = '0, m_res_t = '0, m_out_z = '0, m_out_t = '0;
  bit          compare_on = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_done = 0; m_cnt = 0; m_out_z = '0; m_out_t = '0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == 32) begin
          m_busy = 0; m_done = 1; m_out_z = m_res_z; m_out_t = m_res_t;
        end
      end else if (start_i) begin
        m_busy = 1; m_cnt = 0;
        m_res_z = model(0, key_i, block_i, decrypt_i);
        m_res_t = model(1, key_i, block_i, decrypt_i);
      end
    end
  end

  always @(negedge clk) begin
    if (compare_on && !rst) begin
      check("R6 done pulse", {63'd0, done_z}, {63'd0, m_done});
      check("R8 held output", out_z, m_out_z);
      check("R9 alt table output", out_t, m_out_t);
    end
  end

  task automatic run_block(input logic [255:0] k, input logic [63:0] d, input bit dec,
                           output logic [63:0] rz, output logic [63:0] rt, output int lat);
    @(negedge clk);
    key_i = k; block_i = d; decrypt_i = dec; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    lat = 0;
    while (!done_z && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    rz = out_z;
    rt = out_t;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=expired expected=finished");
    finish_run();
  end

  localparam logic [255:0] KAT_KEY =
    256'hffeeddccbbaa99887766554433221100f0f1f2f3f4f5f6f7f8f9fafbfcfdfeff;
  localparam logic [63:0] KAT_PT = 64'hfedcba9876543210;
  localparam logic [63:0] KAT_CT = 64'h4ee901e5c2d8ca3d;

  initial begin
    logic [63:0]  rz, rt, ez, et, ct, ctt, pt;
    logic [255:0] k;
    int           lat;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R8 reset block_o", out_z, 64'd0);
    check("R8 reset done_o", {63'd0, done_z}, 64'd0);
    compare_on = 1;

    // R1 R2 R3 R5: known answer for the parameter-Z set
    run_block(KAT_KEY, KAT_PT, 1'b0, rz, rt, lat);
    check("R1 R2 R3 R5 known-answer encrypt", rz, KAT_CT);
    check("R6 latency", 64'(lat), 64'd32);
    check("R9 alt set encrypt", rt, model(1, KAT_KEY, KAT_PT, 1'b0));

    // R4: decrypt the known ciphertext
    run_block(KAT_KEY, KAT_CT, 1'b1, rz, rt, lat);
    check("R4 known-answer decrypt", rz, KAT_PT);

    // R4 R9: random round trips on both table sets
    for (int n = 0; n < 12; n++) begin
      k  = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      pt = {$urandom, $urandom};
      run_block(k, pt, 1'b0, ct, ctt, lat);
      check("R3 random encrypt", ct, model(0, k, pt, 1'b0));
      check("R9 random encrypt alt", ctt, model(1, k, pt, 1'b0));
      run_block(k, ct, 1'b1, rz, rt, lat);
      check("R4 round trip", rz, pt);
      run_block(k, ctt, 1'b1, rz, rt, lat);
      check("R4 R9 round trip alt", rt, pt);
    end

    // R7: restart attempt and input changes mid-block are ignored
    ez = model(0, KAT_KEY, KAT_PT, 1'b0);
    et = model(1, KAT_KEY, KAT_PT, 1'b0);
    @(negedge clk);
    key_i = KAT_KEY; block_i = KAT_PT; decrypt_i = 1'b0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (5) @(negedge clk);
    key_i = ~KAT_KEY; block_i = 64'h0123456789abcdef; decrypt_i = 1'b1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (20) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    lat = 0;
    while (!done_z && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    check("R7 result of original block", out_z, ez);
    check("R7 alt result of original block", out_t, et);
    repeat (40) @(negedge clk);
    check("R7 no late restart, done idle", {63'd0, done_z}, 64'd0);
    check("R8 output still held", out_z, ez);

    // R10: same inputs give same result after other traffic
    run_block(KAT_KEY, KAT_PT, 1'b0, rz, rt, lat);
    check("R10 repeat block", rz, KAT_CT);
    run_block(KAT_KEY, KAT_PT, 1'b0, rz, rt, lat);
    check("R10 back-to-back repeat", rz, KAT_CT);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule